// File: doc/BRIEF.md
# Dual-Rail Jitter Attenuation Elastic Buffer

This block carries a two-rail serial line signal, one positive-rail bit and one negative-rail bit per bit period, from a jittery write clock to a smoothed read clock. On every write-clock edge one two-bit sample goes into a circular store. On every read-clock edge one stored sample is moved to a pair of registered output rails. The loop that produces the smoothed clock lies outside the block, and that clock arrives here as an input.

The store works in one of two depths, picked at run time by `depth_sel`: the short depth (16 entries by default) or the long depth (32 entries by default). Reset, and also any change of `depth_sel`, places the write pointer half the depth ahead of the read pointer. With equal clock rates the output therefore trails the input by half the depth. Each pointer is sent to the other domain in Gray code through a synchronizer. In the read domain the separation between the pointers is compared with a guard margin, and a registered limit alarm is raised when the pointers come close to colliding from either side.

Top module: `dr_jitter_fifo`

## Requirements
- R1: A write-clock edge stores `in_p` and `in_n` as one entry. Bit 1 of the entry is the positive rail and bit 0 is the negative rail, and both come back out together on `out_p` and `out_n`.
- R2: Each read-clock edge loads `out_p` and `out_n` from the entry at the read pointer and then advances the pointer by one. A read taken while writes are stalled returns whatever that slot holds at that moment.
- R3: With `depth_sel` = 0 (short depth, 16) and both clocks on one edge train, the sample written on write edge k after reset appears on the outputs right after read edge k+8. Before that the outputs are 0, because reset clears the store.
- R4: With `depth_sel` = 1 (long depth, 32) the same rule holds with a latency of 16 edges.
- R5: Both pointers step by one per edge of their own clock and wrap from the last slot of the selected depth back to 0. The data order stays correct across many wraps.
- R6: The alarm goes high when the separation, computed in the read domain as (synchronized write pointer − read pointer) mod depth, is 2 or less.
- R7: The alarm goes high when that separation is the depth minus 2 or more.
- R8: `limit_alarm` is a register in the read domain. It updates on read edges only, using the separation as it stood before that edge. It is 0 during reset and stays 0 under nominal spacing.
- R9: A change of `depth_sel` passes through two stages in each domain and then reinitializes that domain as reset does. The write pointer goes to half the new depth and the read pointer to 0. The store keeps its contents, no sample is stored on that write edge, the outputs hold on that read edge, and the alarm clears.
- R10: `rst_n` is sampled synchronously in each domain. While it is low, the outputs and the alarm are driven to 0, the store is cleared, and the depth is taken straight from `depth_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Jittery write clock |
| rd_clk | input | 1 | Smoothed read clock |
| rst_n | input | 1 | Active-low reset, sampled in both domains |
| depth_sel | input | 1 | 0 selects the short depth, 1 selects the long depth |
| in_p | input | 1 | Positive-rail input bit |
| in_n | input | 1 | Negative-rail input bit |
| out_p | output | 1 | Registered positive-rail output bit |
| out_n | output | 1 | Registered negative-rail output bit |
| limit_alarm | output | 1 | Pointers near collision (read domain) |

## Verification
The bench stalls the write clock while reads continue, which drives the separation down through the underflow margin. A design with an off-by-one margin, or one that reads the write pointer without the synchronizer delay, would raise or drop the alarm one edge off. It then stalls the read clock while writes continue, to reach the overflow side; a design with the wrong wrap mask would alarm in the wrong mode or never alarm. Runs long enough to wrap the pointers several times in both depths catch a pointer that wraps at the wrong slot, which shows up as a shifted or repeated sample. A mid-run depth change followed by a clean latency of 16 exposes a design that ignores `depth_sel` after reset or reinitializes only one side.

// File: rtl/jab_pkg.sv
package jab_pkg;

   localparam int GW = 8;

   typedef enum logic { DM_SHORT = 1'b0, DM_LONG = 1'b1 } depth_mode_e;

   function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
      logic [GW-1:0] b;
      b[GW-1] = g[GW-1];
      for (int i = GW-2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/jab_sync.sv
module jab_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("jab_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (load) stg[0] <= load_val;
      else      stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (load) stg[i] <= load_val;
         else      stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/jab_store.sv
module jab_store #(
   parameter int DEPTH     = 32,
   parameter int AW        = 5,
   parameter bit CLEAR_RST = 1'b1
) (
   input  logic          wr_clk,
   input  logic          clr,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [1:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [1:0]    rdata
);

   logic [1:0] mem [DEPTH];

   if (CLEAR_RST) begin : g_clear
      always_ff @(posedge wr_clk) begin
         if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 2'b00;
         end else if (we) begin
            mem[waddr] <= wdata;
         end
      end
   end else begin : g_noclear
      always_ff @(posedge wr_clk) begin
         if (we && !clr) mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/jab_wr_side.sv
module jab_wr_side
   import jab_pkg::*;
#(
   parameter int MIN_DEPTH   = 16,
   parameter int MAX_DEPTH   = 32,
   parameter int AW          = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          depth_sel,
   input  logic          in_p,
   input  logic          in_n,
   output logic          we,
   output logic          clr,
   output logic [AW-1:0] waddr,
   output logic [1:0]    wdata,
   output logic [AW-1:0] wr_gray,
   output logic [AW-1:0] wr_ptr,
   output logic          wr_long,
   output logic          wr_reinit
);

   localparam logic [AW-1:0] HALF_S = AW'(MIN_DEPTH / 2);
   localparam logic [AW-1:0] HALF_L = AW'(MAX_DEPTH / 2);
   localparam logic [AW-1:0] LAST_S = AW'(MIN_DEPTH - 1);
   localparam logic [AW-1:0] LAST_L = AW'(MAX_DEPTH - 1);

   function automatic logic [AW-1:0] half_of(input logic lng);
      return (lng == DM_LONG) ? HALF_L : HALF_S;
   endfunction

   function automatic logic [AW-1:0] gray_of(input logic [AW-1:0] v);
      logic [GW-1:0] t;
      t = to_gray(GW'(v));
      return t[AW-1:0];
   endfunction

   logic          ds_s;
   logic          cur_q;
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] gray_q;
   logic [AW-1:0] ptr_nxt;
   logic [AW-1:0] last_slot;

   jab_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ds_sync (
      .clk      (wr_clk),
      .load     (!rst_n),
      .load_val (depth_sel),
      .d        (depth_sel),
      .q        (ds_s)
   );

   assign wr_reinit = rst_n && (ds_s != cur_q);
   assign last_slot = (cur_q == DM_LONG) ? LAST_L : LAST_S;
   assign ptr_nxt   = (ptr_q == last_slot) ? '0 : ptr_q + AW'(1);

   always_ff @(posedge wr_clk) begin
      if (!rst_n) begin
         cur_q  <= depth_sel;
         ptr_q  <= half_of(depth_sel);
         gray_q <= gray_of(half_of(depth_sel));
      end else if (wr_reinit) begin
         cur_q  <= ds_s;
         ptr_q  <= half_of(ds_s);
         gray_q <= gray_of(half_of(ds_s));
      end else begin
         ptr_q  <= ptr_nxt;
         gray_q <= gray_of(ptr_nxt);
      end
   end

   assign we      = rst_n && !wr_reinit;
   assign clr     = !rst_n;
   assign waddr   = ptr_q;
   assign wdata   = {in_p, in_n};
   assign wr_gray = gray_q;
   assign wr_ptr  = ptr_q;
   assign wr_long = cur_q;

endmodule

// File: rtl/jab_rd_side.sv
module jab_rd_side
   import jab_pkg::*;
#(
   parameter int MIN_DEPTH    = 16,
   parameter int MAX_DEPTH    = 32,
   parameter int AW           = 5,
   parameter int SYNC_STAGES  = 2,
   parameter int LIMIT_MARGIN = 2
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          depth_sel,
   input  logic [AW-1:0] wr_gray,
   input  logic [1:0]    rdata,
   output logic [AW-1:0] raddr,
   output logic          out_p,
   output logic          out_n,
   output logic          limit_alarm,
   output logic [AW-1:0] rd_ptr,
   output logic          rd_long,
   output logic          rd_reinit
);

   localparam logic [AW-1:0] HALF_S = AW'(MIN_DEPTH / 2);
   localparam logic [AW-1:0] HALF_L = AW'(MAX_DEPTH / 2);
   localparam logic [AW-1:0] LAST_S = AW'(MIN_DEPTH - 1);
   localparam logic [AW-1:0] LAST_L = AW'(MAX_DEPTH - 1);
   localparam logic [AW:0]   DEP_S  = (AW+1)'(MIN_DEPTH);
   localparam logic [AW:0]   DEP_L  = (AW+1)'(MAX_DEPTH);
   localparam logic [AW:0]   MARG   = (AW+1)'(LIMIT_MARGIN);

   function automatic logic [AW-1:0] half_of(input logic lng);
      return (lng == DM_LONG) ? HALF_L : HALF_S;
   endfunction

   function automatic logic [AW-1:0] gray_of(input logic [AW-1:0] v);
      logic [GW-1:0] t;
      t = to_gray(GW'(v));
      return t[AW-1:0];
   endfunction

   function automatic logic [AW-1:0] bin_of(input logic [AW-1:0] g);
      logic [GW-1:0] t;
      t = from_gray(GW'(g));
      return t[AW-1:0];
   endfunction

   logic          ds_s;
   logic          cur_q;
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] ptr_nxt;
   logic [AW-1:0] last_slot;
   logic [AW-1:0] ws_gray;
   logic [AW-1:0] ws_load;
   logic [AW-1:0] sep;
   logic [AW:0]   dep_cur;
   logic          near;
   logic          pos_q;
   logic          neg_q;
   logic          alarm_q;

   jab_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ds_sync (
      .clk      (rd_clk),
      .load     (!rst_n),
      .load_val (depth_sel),
      .d        (depth_sel),
      .q        (ds_s)
   );

   assign ws_load = gray_of(half_of(rst_n ? ds_s : depth_sel));

   jab_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_wp_sync (
      .clk      (rd_clk),
      .load     (!rst_n || rd_reinit),
      .load_val (ws_load),
      .d        (wr_gray),
      .q        (ws_gray)
   );

   assign rd_reinit = rst_n && (ds_s != cur_q);
   assign last_slot = (cur_q == DM_LONG) ? LAST_L : LAST_S;
   assign dep_cur   = (cur_q == DM_LONG) ? DEP_L : DEP_S;
   assign ptr_nxt   = (ptr_q == last_slot) ? '0 : ptr_q + AW'(1);
   assign sep       = (bin_of(ws_gray) - ptr_q) & last_slot;
   assign near      = ({1'b0, sep} <= MARG) || ({1'b0, sep} >= (dep_cur - MARG));

   always_ff @(posedge rd_clk) begin
      if (!rst_n) begin
         cur_q   <= depth_sel;
         ptr_q   <= '0;
         pos_q   <= 1'b0;
         neg_q   <= 1'b0;
         alarm_q <= 1'b0;
      end else if (rd_reinit) begin
         cur_q   <= ds_s;
         ptr_q   <= '0;
         alarm_q <= 1'b0;
      end else begin
         ptr_q   <= ptr_nxt;
         pos_q   <= rdata[1];
         neg_q   <= rdata[0];
         alarm_q <= near;
      end
   end

   assign raddr       = ptr_q;
   assign out_p       = pos_q;
   assign out_n       = neg_q;
   assign limit_alarm = alarm_q;
   assign rd_ptr      = ptr_q;
   assign rd_long     = cur_q;

endmodule

// File: rtl/dr_jitter_fifo.sv
module dr_jitter_fifo
   import jab_pkg::*;
#(
   parameter int MIN_DEPTH    = 16,
   parameter int MAX_DEPTH    = 32,
   parameter int SYNC_STAGES  = 2,
   parameter int LIMIT_MARGIN = 2,
   parameter bit CLEAR_RST    = 1'b1
) (
   input  logic wr_clk,
   input  logic rd_clk,
   input  logic rst_n,
   input  logic depth_sel,
   input  logic in_p,
   input  logic in_n,
   output logic out_p,
   output logic out_n,
   output logic limit_alarm
);

   localparam int AW = $clog2(MAX_DEPTH);

   if (MAX_DEPTH != 2 * MIN_DEPTH) begin : g_bad_ratio
      $error("long depth must be twice the short depth");
   end
   if ((1 << AW) != MAX_DEPTH) begin : g_bad_pow2
      $error("depths must be powers of two");
   end
   if (AW > GW) begin : g_bad_width
      $error("pointer wider than package Gray helpers");
   end
   if (MIN_DEPTH / 2 - SYNC_STAGES <= LIMIT_MARGIN) begin : g_bad_margin
      $error("margin would alarm under nominal spacing");
   end

   logic          we;
   logic          clr;
   logic [AW-1:0] waddr;
   logic [1:0]    wdata;
   logic [AW-1:0] raddr;
   logic [1:0]    rdata;
   logic [AW-1:0] wr_gray;
   logic [AW-1:0] wr_ptr;
   logic          wr_long;
   logic          wr_reinit;
   logic [AW-1:0] rd_ptr;
   logic          rd_long;
   logic          rd_reinit;

   jab_wr_side #(
      .MIN_DEPTH(MIN_DEPTH), .MAX_DEPTH(MAX_DEPTH), .AW(AW), .SYNC_STAGES(SYNC_STAGES)
   ) u_wr (
      .wr_clk    (wr_clk),
      .rst_n     (rst_n),
      .depth_sel (depth_sel),
      .in_p      (in_p),
      .in_n      (in_n),
      .we        (we),
      .clr       (clr),
      .waddr     (waddr),
      .wdata     (wdata),
      .wr_gray   (wr_gray),
      .wr_ptr    (wr_ptr),
      .wr_long   (wr_long),
      .wr_reinit (wr_reinit)
   );

   jab_store #(.DEPTH(MAX_DEPTH), .AW(AW), .CLEAR_RST(CLEAR_RST)) u_store (
      .wr_clk (wr_clk),
      .clr    (clr),
      .we     (we),
      .waddr  (waddr),
      .wdata  (wdata),
      .raddr  (raddr),
      .rdata  (rdata)
   );

   jab_rd_side #(
      .MIN_DEPTH(MIN_DEPTH), .MAX_DEPTH(MAX_DEPTH), .AW(AW),
      .SYNC_STAGES(SYNC_STAGES), .LIMIT_MARGIN(LIMIT_MARGIN)
   ) u_rd (
      .rd_clk      (rd_clk),
      .rst_n       (rst_n),
      .depth_sel   (depth_sel),
      .wr_gray     (wr_gray),
      .rdata       (rdata),
      .raddr       (raddr),
      .out_p       (out_p),
      .out_n       (out_n),
      .limit_alarm (limit_alarm),
      .rd_ptr      (rd_ptr),
      .rd_long     (rd_long),
      .rd_reinit   (rd_reinit)
   );

endmodule

// File: rtl/jab_checker.sv
module jab_checker #(
   parameter int MIN_DEPTH = 16,
   parameter int MAX_DEPTH = 32,
   parameter int AW        = 5
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          out_p,
   input logic          out_n,
   input logic          limit_alarm,
   input logic [AW-1:0] wr_ptr,
   input logic          wr_long,
   input logic          wr_reinit,
   input logic [AW-1:0] wr_gray,
   input logic [AW-1:0] rd_ptr,
   input logic          rd_long,
   input logic          rd_reinit
);

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic lng);
      logic [AW-1:0] last;
      last = lng ? AW'(MAX_DEPTH - 1) : AW'(MIN_DEPTH - 1);
      return (p == last) ? '0 : p + AW'(1);
   endfunction

   logic rd_rst_seen;
   always_ff @(posedge rd_clk) rd_rst_seen <= !rst_n;

   // R10: outputs are cleared by a reset edge
   always @(negedge rd_clk) begin
      if (rd_rst_seen) begin
         a_r10_out_cleared: assert (!out_p && !out_n)
            else $error("outputs not cleared in reset");
      end
   end

   // R8: alarm is low on the first edge after reset
   a_r8_quiet_after_reset: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $past(!rst_n) |-> !limit_alarm);

   // R9: a depth change clears the alarm
   a_r9_reinit_clears_alarm: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_reinit |=> !limit_alarm);

   // R5: write pointer steps by one and wraps at the selected depth
   a_r5_wr_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_reinit)) |-> (wr_ptr == step($past(wr_ptr), $past(wr_long))));

   // R5: read pointer steps by one and wraps at the selected depth
   a_r5_rd_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(rd_reinit)) |-> (rd_ptr == step($past(rd_ptr), $past(rd_long))));

   // R5: the Gray word sent across changes one bit per normal step
   a_r5_gray_one_bit: assert property (@(posedge wr_clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_reinit)) |-> ($countones(wr_gray ^ $past(wr_gray)) == 1));

endmodule

bind dr_jitter_fifo jab_checker #(
   .MIN_DEPTH(MIN_DEPTH), .MAX_DEPTH(MAX_DEPTH), .AW(AW)
) u_chk (
   .wr_clk      (wr_clk),
   .rd_clk      (rd_clk),
   .rst_n       (rst_n),
   .out_p       (out_p),
   .out_n       (out_n),
   .limit_alarm (limit_alarm),
   .wr_ptr      (wr_ptr),
   .wr_long     (wr_long),
   .wr_reinit   (wr_reinit),
   .wr_gray     (wr_gray),
   .rd_ptr      (rd_ptr),
   .rd_long     (rd_long),
   .rd_reinit   (rd_reinit)
);

// File: tb/dr_jitter_fifo_bench.sv
`timescale 1ns/1ps
module dr_jitter_fifo_bench;

   logic clk = 1'b0;
   logic wen = 1'b1;
   logic ren = 1'b1;
   logic rst_n = 1'b0;
   logic depth_sel = 1'b0;
   logic in_p = 1'b0;
   logic in_n = 1'b0;
   logic out_p, out_n, limit_alarm;
   logic wr_clk, rd_clk;

   always #10 clk = ~clk;
   assign wr_clk = clk & wen;
   assign rd_clk = clk & ren;

   dr_jitter_fifo u_dr_jitter_fifo (
      .wr_clk (wr_clk), .rd_clk (rd_clk), .rst_n (rst_n), .depth_sel (depth_sel),
      .in_p (in_p), .in_n (in_n), .out_p (out_p), .out_n (out_n),
      .limit_alarm (limit_alarm)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   string rq_data = "R10";
   string rq_alarm = "R8";

   // reference model state
   bit [1:0] m_mem [32];
   int  m_wp, m_rp, m_ws1, m_ws2;
   bit  m_wcur, m_rcur, m_wds1, m_wds2, m_rds1, m_rds2;
   bit [1:0] m_out;
   bit  m_al;

   function automatic int dep(input bit lng);
      return lng ? 32 : 16;
   endfunction

   always @(posedge clk) begin
      int wp_old;
      int sep;
      wp_old = m_wp;
      if (!rst_n) begin
         m_wcur = depth_sel; m_rcur = depth_sel;
         m_wds1 = depth_sel; m_wds2 = depth_sel;
         m_rds1 = depth_sel; m_rds2 = depth_sel;
         m_wp = dep(depth_sel) / 2; m_rp = 0;
         m_ws1 = m_wp; m_ws2 = m_wp;
         for (int i = 0; i < 32; i++) m_mem[i] = 2'b00;
         m_out = 2'b00; m_al = 1'b0;
      end else begin
         if (ren) begin
            if (m_rds2 != m_rcur) begin
               m_rcur = m_rds2; m_rp = 0;
               m_ws1 = dep(m_rcur) / 2; m_ws2 = m_ws1; m_al = 1'b0;
            end else begin
               sep = ((m_ws2 - m_rp) % dep(m_rcur) + dep(m_rcur)) % dep(m_rcur);
               m_al = (sep <= 2) || (sep >= dep(m_rcur) - 2);
               m_out = m_mem[m_rp];
               m_rp = (m_rp + 1) % dep(m_rcur);
               m_ws2 = m_ws1; m_ws1 = wp_old;
            end
            m_rds2 = m_rds1; m_rds1 = depth_sel;
         end
         if (wen) begin
            if (m_wds2 != m_wcur) begin
               m_wcur = m_wds2; m_wp = dep(m_wcur) / 2;
            end else begin
               m_mem[m_wp] = {in_p, in_n};
               m_wp = (m_wp + 1) % dep(m_wcur);
            end
            m_wds2 = m_wds1; m_wds1 = depth_sel;
         end
      end
   end

   task automatic compare();
      compared++;
      if ({out_p, out_n} !== m_out) begin
         mismatched++;
         $display("FAIL %s rails: actual %b%b expected %b", rq_data, out_p, out_n, m_out);
      end
      compared++;
      if (limit_alarm !== m_al) begin
         mismatched++;
         $display("FAIL %s alarm: actual %b expected %b", rq_alarm, limit_alarm, m_al);
      end
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         compare();
         in_p = 1'($urandom);
         in_n = 1'($urandom);
      end
   endtask

   initial begin
      // R10 reset, short depth
      rq_data = "R10"; rq_alarm = "R8";
      ticks(6);
      rst_n = 1'b1;
      // R2 and R3: outputs 0 until the first sample, then 8 edges of latency
      rq_data = "R3"; rq_alarm = "R8";
      ticks(12);
      rq_data = "R2";
      ticks(20);
      // R5 many wraps in short depth
      rq_data = "R5";
      ticks(60);
      // R6 write stall drives separation down
      rq_data = "R2"; rq_alarm = "R6";
      wen = 1'b0;
      ticks(10);
      wen = 1'b1;
      ticks(12);
      // R7 read stall drives separation up
      rq_data = "R1"; rq_alarm = "R7";
      ren = 1'b0;
      ticks(14);
      ren = 1'b1;
      ticks(12);
      ren = 1'b0;
      ticks(9);
      ren = 1'b1;
      ticks(10);
      // R9 change depth on the fly
      rq_data = "R9"; rq_alarm = "R9";
      depth_sel = 1'b1;
      ticks(40);
      // R4 long depth steady run
      rq_data = "R4"; rq_alarm = "R8";
      ticks(80);
      // R6 in long depth
      rq_data = "R4"; rq_alarm = "R6";
      wen = 1'b0;
      ticks(20);
      wen = 1'b1;
      ticks(10);
      rq_alarm = "R7";
      ren = 1'b0;
      ticks(30);
      ren = 1'b1;
      ticks(10);
      // R10 reset in long depth, then R4 latency from reset
      rq_data = "R10"; rq_alarm = "R8";
      rst_n = 1'b0;
      ticks(5);
      rst_n = 1'b1;
      rq_data = "R4";
      ticks(60);
      // R9 back to short depth
      rq_data = "R9"; rq_alarm = "R9";
      depth_sel = 1'b0;
      ticks(50);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule